// File: doc/BRIEF.md
# Register Initialisation Sequencer

This block brings a peripheral device into a known configuration. It walks a small table of byte triples held inside the block. For each triple it issues accesses on a simple request/acknowledge register bus. A triple either programs one device register or makes the walk pause for a number of millisecond ticks. A triple can also mark the end of the table. A register access is a plain write when the mask selects every bit. Otherwise it is a read, then a merge under the mask, then a write back to the same register.

While the block is idle, the host fills or patches the table one byte at a time, for example to insert a board-specific offset constant. The host then pulses `start`. `busy` stays high for the whole walk. A one-cycle `done` pulse reports success. If the bus reports an error, the walk stops and `err` is raised. `err` stays high until the next start.

Top module: `reg_init_seq`

## Requirements
- R1: Entry k occupies table bytes 3k (register address), 3k+1 (mask) and 3k+2 (value). A start walks the entries from entry 0 in increasing order.
- R2: For an entry whose mask is 0xFF, exactly one bus write of the value byte is issued to the register address, with no read.
- R3: For an entry whose mask is not 0xFF and whose address is not 0xFF, the block first issues a bus read of the address. It then writes (read data AND NOT mask) OR (value AND mask) back to the same address.
- R4: An entry with address 0xFF and mask 0xFF ends the walk. `done` is high for exactly one cycle, `busy` drops in the same cycle, and no further bus access follows.
- R5: An entry with address 0xFF and mask N (N not 0xFF) issues no bus access. The walk resumes after N `ms_tick` pulses, counted from the cycle in which that entry is reached.
- R6: A byte write on the host port (`cfg_we`, byte index `cfg_addr`) replaces that table byte when the block is idle. While `busy` is high, such a write has no effect.
- R7: At most one bus access is outstanding. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable until `bus_ack`. `bus_req` is low whenever the block is idle.
- R8: `bus_err` sampled with `bus_ack` aborts the walk. No further access is issued, `done` is not pulsed, `err` goes high and stays high until the next start, and the next start clears it.
- R9: `start` has no effect while `busy` is high.
- R10: If the walk passes the last table entry without meeting an end entry, it ends as in R4.
- R11: After reset, every table byte is 0xFF and `busy`, `done`, `err` and `bus_req` are low. A start straight after reset therefore ends at once with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a table walk when idle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_we | input | 1 | Host table byte write enable |
| cfg_addr | input | $clog2(3*ENTRIES) | Host table byte index |
| cfg_wdata | input | 8 | Host table byte data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk completes |
| err | output | 1 | Sticky bus error flag |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |

## Verification
A wrong entry pointer or state shows up on the very next bus request, which carries the wrong address, type or data. It may also show as an access that should not exist, or as a missing done pulse. A delay counter that is off by one moves the next request, or the done pulse, by a whole tick period. The bench therefore compares every request against a behavioural queue of the accesses it expects. It also compares the number of ticks elapsed before each request against the delays it expects, and compares the device register image once the walk has ended.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam logic [7:0] MARK = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_READ,
        ST_WRITE,
        ST_WAIT
    } rseq_state_e;
endpackage

// File: rtl/rseq_table.sv
module rseq_table #(
    parameter int ENTRIES = 16,
    parameter int BW      = 6,
    parameter int IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [IW-1:0] rd_ent,
    output logic [7:0]    ent_addr,
    output logic [7:0]    ent_mask,
    output logic [7:0]    ent_val
);
    import rseq_pkg::*;

    localparam int NBYTES = ENTRIES * 3;

    logic [7:0]    mem_q [NBYTES];
    logic [7:0]    mem_d [NBYTES];
    logic [BW-1:0] base;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_idx) < NBYTES)) begin
            mem_d[wr_idx] = wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                mem_q[i] <= MARK;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        base     = BW'(rd_ent) * BW'(3);
        ent_addr = mem_q[base];
        ent_mask = mem_q[base + BW'(1)];
        ent_val  = mem_q[base + BW'(2)];
    end
endmodule

// File: rtl/rseq_delay.sv
module rseq_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         fin
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } dly_t;

    dly_t d, q;

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (load) begin
            if (load_val == '0) begin
                fin = 1'b1;
            end else if (tick && (load_val == W'(1))) begin
                fin = 1'b1;
            end else begin
                d.run = 1'b1;
                d.cnt = tick ? (load_val - W'(1)) : load_val;
            end
        end else if (q.run && tick) begin
            if (q.cnt == W'(1)) begin
                fin   = 1'b1;
                d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run <= 1'b0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.cnt != '0)) else $error("delay counter running at zero"); // R5
endmodule

// File: rtl/reg_init_seq.sv
module reg_init_seq #(
    parameter int ENTRIES = 16,
    localparam int NBYTES = ENTRIES * 3,
    localparam int CAW    = $clog2(NBYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           ms_tick,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [7:0]     cfg_wdata,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic           bus_req,
    output logic           bus_we,
    output logic [7:0]     bus_addr,
    output logic [7:0]     bus_wdata,
    input  logic           bus_ack,
    input  logic           bus_err,
    input  logic [7:0]     bus_rdata
);
    import rseq_pkg::*;

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int PW = $clog2(ENTRIES + 1);

    typedef struct packed {
        rseq_state_e   st;
        logic [PW-1:0] ptr;
        logic          req;
        logic          we;
        logic [7:0]    addr;
        logic [7:0]    wdata;
        logic          done;
        logic          err;
    } seq_t;

    seq_t d, q;

    logic [7:0] e_addr, e_mask, e_val;
    logic       at_end, dly_load, dly_fin, tbl_we;

    assign tbl_we   = cfg_we && (q.st == ST_IDLE);
    assign at_end   = (q.ptr == PW'(ENTRIES));
    assign dly_load = (q.st == ST_EXEC) && !at_end && (e_addr == MARK) && (e_mask != MARK);

    rseq_table #(.ENTRIES(ENTRIES), .BW(CAW), .IW(IW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (cfg_addr),
        .wr_byte  (cfg_wdata),
        .rd_ent   (q.ptr[IW-1:0]),
        .ent_addr (e_addr),
        .ent_mask (e_mask),
        .ent_val  (e_val)
    );

    rseq_delay #(.W(8)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (e_mask),
        .tick     (ms_tick),
        .fin      (dly_fin)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_EXEC;
                    d.ptr = '0;
                    d.err = 1'b0;
                end
            end
            ST_EXEC: begin
                if (at_end || ((e_addr == MARK) && (e_mask == MARK))) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (e_addr == MARK) begin
                    if (dly_fin) begin
                        d.ptr = q.ptr + PW'(1);
                    end else begin
                        d.st = ST_WAIT;
                    end
                end else begin
                    d.req   = 1'b1;
                    d.addr  = e_addr;
                    d.wdata = e_val;
                    d.we    = (e_mask == MARK);
                    d.st    = (e_mask == MARK) ? ST_WRITE : ST_READ;
                end
            end
            ST_READ: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        d.req = 1'b0;
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.we    = 1'b1;
                        d.wdata = (bus_rdata & ~e_mask) | (e_val & e_mask);
                        d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ack) begin
                    d.req = 1'b0;
                    if (bus_err) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.ptr = q.ptr + PW'(1);
                        d.st  = ST_EXEC;
                    end
                end
            end
            ST_WAIT: begin
                if (dly_fin) begin
                    d.ptr = q.ptr + PW'(1);
                    d.st  = ST_EXEC;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.ptr   <= '0;
            q.req   <= 1'b0;
            q.we    <= 1'b0;
            q.addr  <= '0;
            q.wdata <= '0;
            q.done  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)))
        else $error("request changed before ack"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req) else $error("request while idle"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err) else $error("error flag dropped"); // R8
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !busy)) else $error("error with done or busy"); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (q.ptr != '0)) |=> (q.ptr != '0)) else $error("walk restarted while busy"); // R9
endmodule

// File: tb/sim_reg_init_seq.sv
module sim_reg_init_seq;
    localparam int ENTRIES = 16;
    localparam int NB      = ENTRIES * 3;
    localparam int CAW     = $clog2(NB);
    localparam int TICKP   = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0, start = 1'b0, ms_tick = 1'b0, cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [7:0]     cfg_wdata = '0;
    logic           busy, done, err, bus_req, bus_we;
    logic [7:0]     bus_addr, bus_wdata;
    logic           bus_ack = 1'b0, bus_err = 1'b0;
    logic [7:0]     bus_rdata = '0;

    reg_init_seq #(.ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .done(done), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] tb_tbl [NB];
    logic [7:0] dev_mem [256];
    logic [7:0] mod_mem [256];
    int q_we[$], q_addr[$], q_data[$], q_tk[$];
    int exp_end_tk, err_addr, lat, lat_cnt, tk_since, done_cnt, n_unexp, cyc;
    bit exp_err, req_seen, prev_busy;

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_byte(int idx, logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CAW'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        tb_tbl[idx] = v;
    endtask

    task automatic set_ent(int e, logic [7:0] a, logic [7:0] m, logic [7:0] v);
        set_byte(3*e, a); set_byte(3*e+1, m); set_byte(3*e+2, v);
    endtask

    task automatic build_model();
        int acc;
        logic [7:0] a, m, v, nv;
        acc = 0; exp_err = 1'b0;
        q_we.delete(); q_addr.delete(); q_data.delete(); q_tk.delete();
        for (int i = 0; i < 256; i++) mod_mem[i] = dev_mem[i];
        for (int e = 0; e < ENTRIES; e++) begin
            a = tb_tbl[3*e]; m = tb_tbl[3*e+1]; v = tb_tbl[3*e+2];
            if (a == 8'hFF) begin
                if (m == 8'hFF) break;
                acc += m;
            end else if (m == 8'hFF) begin
                q_we.push_back(1); q_addr.push_back(a); q_data.push_back(v); q_tk.push_back(acc);
                acc = 0;
                if (int'(a) == err_addr) begin exp_err = 1'b1; break; end
                mod_mem[a] = v;
            end else begin
                q_we.push_back(0); q_addr.push_back(a); q_data.push_back(0); q_tk.push_back(acc);
                acc = 0;
                if (int'(a) == err_addr) begin exp_err = 1'b1; break; end
                nv = (mod_mem[a] & ~m) | (v & m);
                q_we.push_back(1); q_addr.push_back(a); q_data.push_back(nv); q_tk.push_back(0);
                mod_mem[a] = nv;
            end
        end
        exp_end_tk = acc;
    endtask

    // bus device, tick source and request monitor, all at the falling edge
    always @(negedge clk) begin
        int ewe, ea, ed, et;
        cyc++;
        if (done) begin
            done_cnt++;
            if (exp_end_tk > 0) chk(tk_since == exp_end_tk, "R5", "ticks before done", tk_since, exp_end_tk);
        end
        if (busy && !prev_busy) tk_since = 0;
        prev_busy = busy;
        if (bus_req && !bus_ack && !req_seen) begin
            req_seen = 1'b1; lat_cnt = 0;
            if (q_we.size() == 0) begin
                n_unexp++;
                chk(1'b0, "R7", "unexpected access", bus_addr, 0);
            end else begin
                ewe = q_we.pop_front(); ea = q_addr.pop_front();
                ed = q_data.pop_front(); et = q_tk.pop_front();
                chk(int'(bus_we) == ewe, ewe ? "R2" : "R3", "access type", bus_we, ewe);
                chk(int'(bus_addr) == ea, "R1", "access address", bus_addr, ea);
                if (ewe == 1) chk(int'(bus_wdata) == ed, "R3", "write data", bus_wdata, ed);
                if (et > 0) chk(tk_since == et, "R5", "ticks before access", tk_since, et);
            end
        end
        if (bus_ack) begin
            bus_ack = 1'b0; bus_err = 1'b0; req_seen = 1'b0;
        end else if (bus_req && req_seen) begin
            if (lat_cnt >= lat) begin
                bus_ack = 1'b1; tk_since = 0;
                if (int'(bus_addr) == err_addr) bus_err = 1'b1;
                else if (bus_we) dev_mem[bus_addr] = bus_wdata;
                else bus_rdata = dev_mem[bus_addr];
            end else begin
                lat_cnt++;
            end
        end
        ms_tick = ((cyc % TICKP) == 0);
        if (ms_tick && busy && !bus_req) tk_since++;
    end

    task automatic run(int latency, int eaddr, bit poke, string rq);
        int w, mism;
        lat = latency; err_addr = eaddr; done_cnt = 0; n_unexp = 0;
        build_model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1; cfg_we = 1'b1; cfg_addr = CAW'(3); cfg_wdata = 8'hFF;
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
        end
        w = 0;
        while (busy && w < 20000) begin @(negedge clk); w++; end
        repeat (2) @(negedge clk);
        chk(w < 20000, rq, "walk finished", w, 0);
        chk(done_cnt == (exp_err ? 0 : 1), exp_err ? "R8" : "R4", "done pulses", done_cnt, exp_err ? 0 : 1);
        chk(err == exp_err, "R8", "error flag", err, exp_err);
        chk(q_we.size() == 0, "R7", "missing accesses", q_we.size(), 0);
        if (poke) chk(n_unexp == 0, "R9", "extra accesses after start while busy", n_unexp, 0);
        mism = 0;
        for (int i = 0; i < 256; i++) if (dev_mem[i] !== mod_mem[i]) mism++;
        chk(mism == 0, "R3", "device register image", mism, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dev_mem[i] = 8'(i) ^ 8'h5A;
        for (int i = 0; i < NB; i++) tb_tbl[i] = 8'hFF;
        cyc = 0; tk_since = 0; req_seen = 1'b0; prev_busy = 1'b0; err_addr = -1; lat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !bus_req, "R11", "reset outputs", {busy, done, err, bus_req}, 0);

        // table left at reset value: immediate end
        run(0, -1, 0, "R11");

        // writes, merges and delays; value override; start and table write while busy
        set_ent(0, 8'h10, 8'hFF, 8'h3C);
        set_ent(1, 8'h20, 8'h0F, 8'hA5);
        set_ent(2, 8'hFF, 8'h03, 8'h00);
        set_ent(3, 8'h21, 8'hF0, 8'h0F);
        set_ent(4, 8'hFF, 8'h02, 8'h00);
        set_ent(5, 8'hFF, 8'h64, 8'h00);
        set_ent(6, 8'h11, 8'hFF, 8'h77);
        set_ent(7, 8'hFF, 8'h04, 8'h00);
        set_ent(8, 8'hFF, 8'hFF, 8'hFF);
        set_byte(20, 8'h99);
        run(2, -1, 1, "R9");
        chk(dev_mem[8'h11] == 8'h99, "R6", "overridden value byte", dev_mem[8'h11], 8'h99);
        run(0, -1, 0, "R6");

        // bus error on a read
        run(1, 8'h21, 0, "R8");
        repeat (10) @(negedge clk);
        chk(err && !bus_req && !busy, "R8", "error held, bus quiet", {err, bus_req, busy}, 4);

        // whole table without end entry
        for (int e = 0; e < ENTRIES; e++)
            set_ent(e, 8'(8'h40 + e), (e % 2 == 0) ? 8'hFF : 8'(e * 17), 8'(e * 13));
        run(3, -1, 0, "R10");
        chk(!err, "R8", "error cleared by start", err, 0);

        // bus error on a write
        run(0, 8'h44, 0, "R8");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule